// File: doc/BRIEF.md
# Configuration Load Sequencer

This block runs the power-up configuration handshake of a downstream programmable device over open-drain style pins. A start request picks one of two targets (index 0 is the main device, index 1 the mezzanine device), each wired to its own enable, PROGRAM (active low), INIT and DONE pins. The block first checks that the chosen target has a configuration region. It then raises the target's enable pin, lets go of INIT, and holds PROGRAM low for a set number of cycles. Next it waits for the device to raise INIT, passes the configuration bytes from a valid/ready stream to a byte write strobe, and waits for DONE.

Each wait is bounded by its own cycle limit. The outcome is returned as a two-bit code on a one-cycle completion pulse. INIT and DONE pass through two-flop synchronizers before the sequencer looks at them. The pulse width and both limits are parameters, so a bench can run with small values.

Top module: `cfg_load_seq`

## Requirements
- R1: A load ends with a one-cycle `fin_o` pulse carrying `result_o` (0 success, 1 no configuration region, 2 INIT timeout, 3 DONE timeout). `busy_o` is high from the cycle after an accepted start up to the edge that raises `fin_o`, and low while `fin_o` is high.
- R2: A start whose target has `region_ok_i` low gives `fin_o` with code 1 in the very next cycle. No enable, PROGRAM or INIT pin changes.
- R3: When bit t of `HAS_EN` is set, `en_o[t]` goes high in the cycle after a load of target t is accepted. It is low again by the cycle `fin_o` rises, on success and on failure alike. Targets without the bit keep `en_o` low.
- R4: After reset every `prog_n_o` bit is 1 and every `init_oe_o` bit is 1 (INIT held low). In the cycle after an accepted start, `init_oe_o` of the target is 0 while its `prog_n_o` is still 1, so INIT is released before PROGRAM falls.
- R5: `prog_n_o` of the selected target is low for exactly `PROG_CYC` consecutive cycles per load. No other target's PROGRAM moves.
- R6: If synchronized INIT stays low for `INIT_LIM` polling cycles after PROGRAM rises, the load ends with code 2 and no byte is written.
- R7: Once INIT is seen high, each byte accepted with `s_valid_i` and `s_ready_o` appears one cycle later on `wr_data_o` with `wr_stb_o` high. Bytes come out in arrival order, exactly `byte_cnt_i` of them.
- R8: If synchronized DONE stays low for `DONE_LIM` polling cycles after the last byte, the load ends with code 3. If DONE is seen first, the code is 0.
- R9: A byte count of zero skips the data phase. `s_ready_o` never rises, and the block goes straight from INIT high to the DONE wait.
- R10: A start request while `busy_o` is high is ignored. It touches no pin of any target and does not change the running load's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| tgt_sel_i | input | 1 | Target index (0 main, 1 mezzanine) |
| byte_cnt_i | input | 32 | Number of configuration bytes, latched at start |
| region_ok_i | input | 2 | Per target: a configuration region exists |
| busy_o | output | 1 | Load in progress |
| fin_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | Result code, valid with `fin_o` |
| s_valid_i | input | 1 | Configuration byte valid |
| s_data_i | input | 8 | Configuration byte |
| s_ready_o | output | 1 | Byte accepted this cycle when valid |
| wr_stb_o | output | 1 | Write strobe to the device data port |
| wr_data_o | output | 8 | Byte written to the device data port |
| en_o | output | 2 | Per target enable pin |
| prog_n_o | output | 2 | Per target PROGRAM pin, active low |
| init_oe_o | output | 2 | Per target INIT pull-low enable (1 drives low) |
| init_i | input | 2 | Per target INIT pin level |
| done_i | input | 2 | Per target DONE pin level |

## Verification
The bound checker watches, on every cycle, the ordering and exclusivity rules at the pins:
- INIT is released whenever a PROGRAM pin falls, and only one PROGRAM pin is low at a time.
- The enable pins are low on the completion pulse, and busy is low there.
- Strobes and ready occur only while busy.
- A start without a configuration region completes at once, and a start during busy never produces that completion.

Pulse width, byte order and count, the timeout codes and the zero-count path depend on the device's pin responses. Only the bench's device model shows these, over directed and random loads.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

   typedef enum logic [1:0] {
      RES_OK        = 2'd0,
      RES_NO_REGION = 2'd1,
      RES_NO_INIT   = 2'd2,
      RES_NO_DONE   = 2'd3
   } load_res_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RELEASE,
      ST_PULSE,
      ST_WAIT_INIT,
      ST_STREAM,
      ST_WAIT_DONE
   } seq_st_e;

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfg_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic [CW-1:0] lim_i,
   output logic          expire_o
);

   generate
      if (CW < 1) begin : g_bad_width
         $error("cfg_wait_timer: CW must be positive");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end

   assign expire_o = (cnt_q == lim_i - 1'b1);

endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
   import cfg_load_pkg::*;
#(
   parameter int         NTGT     = 2,
   parameter logic [1:0] HAS_EN   = 2'b11,
   parameter int         PROG_CYC = 32,
   parameter int         INIT_LIM = 10_000_000,
   parameter int         DONE_LIM = 100_000_000,
   parameter int         CNT_W    = 32,
   parameter int         DATA_W   = 8,
   parameter int         SYNC_STG = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              tgt_sel_i,
   input  logic [CNT_W-1:0]  byte_cnt_i,
   input  logic [NTGT-1:0]   region_ok_i,
   output logic              busy_o,
   output logic              fin_o,
   output logic [1:0]        result_o,
   input  logic              s_valid_i,
   input  logic [DATA_W-1:0] s_data_i,
   output logic              s_ready_o,
   output logic              wr_stb_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [NTGT-1:0]   en_o,
   output logic [NTGT-1:0]   prog_n_o,
   output logic [NTGT-1:0]   init_oe_o,
   input  logic [NTGT-1:0]   init_i,
   input  logic [NTGT-1:0]   done_i
);

   localparam int LIM_A   = (PROG_CYC > INIT_LIM) ? PROG_CYC : INIT_LIM;
   localparam int LIM_MAX = (LIM_A > DONE_LIM) ? LIM_A : DONE_LIM;
   localparam int TW      = $clog2(LIM_MAX + 1);

   generate
      if (NTGT != 2) begin : g_bad_ntgt
         $error("cfg_load_seq: exactly two targets are supported");
      end
      if (PROG_CYC < 1 || INIT_LIM < 1 || DONE_LIM < 1) begin : g_bad_lim
         $error("cfg_load_seq: pulse width and limits must be positive");
      end
      if (CNT_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("cfg_load_seq: widths must be positive");
      end
   endgenerate

   seq_st_e          st_q, st_d;
   load_res_e        res_q, res_d;
   logic             fin_q, fin_d;
   logic             tgt_q;
   logic [CNT_W-1:0] left_q;
   logic [NTGT-1:0]  en_q;
   logic [NTGT-1:0]  init_oe_q;
   logic             stb_q;
   logic [DATA_W-1:0] wdat_q;
   logic [NTGT-1:0]  init_s, done_s;
   logic [TW-1:0]    lim;
   logic             expire, tmr_clr, fire, accept;

   cfg_pin_sync #(.W(NTGT), .STAGES(SYNC_STG)) u_init_sync (
      .clk(clk), .rst_n(rst_n), .d_i(init_i), .q_o(init_s));

   cfg_pin_sync #(.W(NTGT), .STAGES(SYNC_STG)) u_done_sync (
      .clk(clk), .rst_n(rst_n), .d_i(done_i), .q_o(done_s));

   cfg_wait_timer #(.CW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .lim_i(lim), .expire_o(expire));

   assign fire   = (st_q == ST_STREAM) && s_valid_i;
   assign accept = (st_q == ST_IDLE) && (st_d == ST_RELEASE);

   always_comb begin
      case (st_q)
         ST_PULSE:     lim = TW'(PROG_CYC);
         ST_WAIT_DONE: lim = TW'(DONE_LIM);
         default:      lim = TW'(INIT_LIM);
      endcase
   end

   always_comb begin
      st_d  = st_q;
      fin_d = 1'b0;
      res_d = RES_OK;
      case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               if (region_ok_i[tgt_sel_i]) begin
                  st_d = ST_RELEASE;
               end else begin
                  fin_d = 1'b1;
                  res_d = RES_NO_REGION;
               end
            end
         end
         ST_RELEASE: st_d = ST_PULSE;
         ST_PULSE: begin
            if (expire) st_d = ST_WAIT_INIT;
         end
         ST_WAIT_INIT: begin
            if (init_s[tgt_q]) begin
               st_d = (left_q == '0) ? ST_WAIT_DONE : ST_STREAM;
            end else if (expire) begin
               st_d  = ST_IDLE;
               fin_d = 1'b1;
               res_d = RES_NO_INIT;
            end
         end
         ST_STREAM: begin
            if (fire && left_q == CNT_W'(1)) st_d = ST_WAIT_DONE;
         end
         ST_WAIT_DONE: begin
            if (done_s[tgt_q]) begin
               st_d  = ST_IDLE;
               fin_d = 1'b1;
               res_d = RES_OK;
            end else if (expire) begin
               st_d  = ST_IDLE;
               fin_d = 1'b1;
               res_d = RES_NO_DONE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   assign tmr_clr = (st_d != st_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         res_q     <= RES_OK;
         fin_q     <= 1'b0;
         tgt_q     <= 1'b0;
         left_q    <= '0;
         en_q      <= '0;
         init_oe_q <= '1;
         stb_q     <= 1'b0;
         wdat_q    <= '0;
      end else begin
         st_q  <= st_d;
         fin_q <= fin_d;
         stb_q <= fire;
         if (fin_d) res_q <= res_d;
         if (fire) wdat_q <= s_data_i;
         if (accept) begin
            tgt_q                <= tgt_sel_i;
            left_q               <= byte_cnt_i;
            en_q[tgt_sel_i]      <= 1'b1;
            init_oe_q[tgt_sel_i] <= 1'b0;
         end else if (fire) begin
            left_q <= left_q - 1'b1;
         end
         if (fin_d && st_q != ST_IDLE) en_q <= '0;
      end
   end

   generate
      for (genvar t = 0; t < NTGT; t++) begin : g_tgt
         if (HAS_EN[t]) begin : g_en
            assign en_o[t] = en_q[t];
         end else begin : g_no_en
            assign en_o[t] = 1'b0;
         end
         assign prog_n_o[t] = !((st_q == ST_PULSE) && (tgt_q == 1'(t)));
      end
   endgenerate

   assign init_oe_o = init_oe_q;
   assign busy_o    = (st_q != ST_IDLE);
   assign fin_o     = fin_q;
   assign result_o  = res_q;
   assign s_ready_o = (st_q == ST_STREAM);
   assign wr_stb_o  = stb_q;
   assign wr_data_o = wdat_q;

endmodule

// File: rtl/cfg_load_seq_chk.sv
module cfg_load_seq_chk #(
   parameter int NTGT = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic            tgt_sel_i,
   input logic [NTGT-1:0] region_ok_i,
   input logic            busy_o,
   input logic            fin_o,
   input logic [1:0]      result_o,
   input logic            s_ready_o,
   input logic            wr_stb_o,
   input logic [NTGT-1:0] en_o,
   input logic [NTGT-1:0] prog_n_o,
   input logic [NTGT-1:0] init_oe_o
);

   AST_FIN_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      fin_o |-> !busy_o); // R1
   AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_o && !start_i) |=> !fin_o); // R1
   AST_NO_REGION_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !region_ok_i[tgt_sel_i]) |=> (fin_o && result_o == 2'd1)); // R2
   AST_NO_REGION_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !region_ok_i[tgt_sel_i]) |=>
         ($stable(prog_n_o) && $stable(init_oe_o) && $stable(en_o))); // R2
   AST_EN_LOW_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      fin_o |-> (en_o == '0)); // R3
   AST_ONE_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~prog_n_o) <= 1); // R5
   AST_STB_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |-> busy_o); // R7
   AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready_o |-> busy_o); // R7
   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !region_ok_i[tgt_sel_i]) |=> !(fin_o && result_o == 2'd1)); // R10

   generate
      for (genvar t = 0; t < NTGT; t++) begin : g_rel
         AST_INIT_RELEASED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(prog_n_o[t]) |-> !init_oe_o[t]); // R4
      end
   endgenerate

endmodule

bind cfg_load_seq cfg_load_seq_chk #(.NTGT(NTGT)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .tgt_sel_i(tgt_sel_i),
   .region_ok_i(region_ok_i), .busy_o(busy_o), .fin_o(fin_o), .result_o(result_o),
   .s_ready_o(s_ready_o), .wr_stb_o(wr_stb_o), .en_o(en_o), .prog_n_o(prog_n_o),
   .init_oe_o(init_oe_o));

// File: tb/test_cfg_load_seq.sv
module test_cfg_load_seq;

   localparam int         PROG = 4;
   localparam int         ILIM = 40;
   localparam int         DLIM = 60;
   localparam logic [1:0] HEN  = 2'b01;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        tgt_sel_i = 1'b0;
   logic [31:0] byte_cnt_i = '0;
   logic [1:0]  region_ok_i = 2'b11;
   logic        busy_o, fin_o, s_ready_o, wr_stb_o;
   logic [1:0]  result_o;
   logic        s_valid_i = 1'b0;
   logic [7:0]  s_data_i = '0;
   logic [7:0]  wr_data_o;
   logic [1:0]  en_o, prog_n_o, init_oe_o, init_i, done_i;
   logic [1:0]  init_lvl = '0;
   logic [1:0]  done_lvl = '0;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   assign init_i[0] = init_oe_o[0] ? 1'b0 : init_lvl[0];
   assign init_i[1] = init_oe_o[1] ? 1'b0 : init_lvl[1];
   assign done_i    = done_lvl;

   cfg_load_seq #(
      .HAS_EN(HEN), .PROG_CYC(PROG), .INIT_LIM(ILIM), .DONE_LIM(DLIM)
   ) i_cfg_load_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .tgt_sel_i(tgt_sel_i),
      .byte_cnt_i(byte_cnt_i), .region_ok_i(region_ok_i), .busy_o(busy_o),
      .fin_o(fin_o), .result_o(result_o), .s_valid_i(s_valid_i), .s_data_i(s_data_i),
      .s_ready_o(s_ready_o), .wr_stb_o(wr_stb_o), .wr_data_o(wr_data_o),
      .en_o(en_o), .prog_n_o(prog_n_o), .init_oe_o(init_oe_o),
      .init_i(init_i), .done_i(done_i));

   function automatic int exp_code(input bit reg_ok, input bit ig, input bit dg);
      if (!reg_ok) return 1;
      if (!ig) return 2;
      if (!dg) return 3;
      return 0;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   task automatic run_load(input int t, input int n, input bit reg_ok, input bit ig, input bit dg);
      logic [7:0] mem [16];
      int exp, wr_n, low_cnt, idx, res, mism, oth;
      bit fire, got_fin, en_end_bad, oth_touch, rdy_seen;
      logic [1:0] oe_before;
      string tag;
      oth = 1 - t;
      exp = exp_code(reg_ok, ig, dg);
      for (int i = 0; i < 16; i++) mem[i] = 8'($urandom);
      init_lvl = '0;
      done_lvl = '0;
      region_ok_i = 2'b00;
      region_ok_i[t] = reg_ok;
      @(negedge clk);
      oe_before = init_oe_o;
      start_i = 1'b1; tgt_sel_i = 1'(t); byte_cnt_i = 32'(n);
      @(negedge clk);
      start_i = 1'b0; byte_cnt_i = 32'hDEAD_BEEF;
      if (!reg_ok) begin
         // R2: immediate code 1, no pin movement
         chk(fin_o && result_o == 2'd1 && !busy_o, "R2 fast code", int'(result_o), 1);
         chk(prog_n_o == 2'b11 && en_o == 2'b00 && init_oe_o == oe_before,
             "R2 pins untouched", int'(init_oe_o), int'(oe_before));
         @(negedge clk);
         return;
      end
      chk(busy_o, "R1 busy after start", int'(busy_o), 1);
      chk(init_oe_o[t] == 1'b0 && prog_n_o[t] == 1'b1, "R4 init released first",
          int'(init_oe_o[t]), 0);
      chk(en_o[t] == HEN[t], "R3 enable during load", int'(en_o[t]), int'(HEN[t]));
      wr_n = 0; low_cnt = 0; idx = 0; res = -1; mism = 0;
      fire = 1'b0; got_fin = 1'b0; en_end_bad = 1'b0; oth_touch = 1'b0; rdy_seen = 1'b0;
      for (int c = 0; c < 4000 && !got_fin; c++) begin
         @(negedge clk);
         if (!prog_n_o[t]) low_cnt++;
         if (!prog_n_o[oth] || en_o[oth] || init_oe_o[oth] != oe_before[oth]) oth_touch = 1'b1;
         if (s_ready_o) rdy_seen = 1'b1;
         if (wr_stb_o) begin
            if (wr_n < 16 && wr_data_o != mem[wr_n]) mism++;
            wr_n++;
         end
         if (fin_o) begin
            got_fin = 1'b1;
            res = int'(result_o);
            if (en_o != 2'b00) en_end_bad = 1'b1;
         end
         if (ig && prog_n_o[t] && low_cnt > 0) init_lvl[t] = 1'b1;
         if (dg && init_lvl[t] && wr_n == n) done_lvl[t] = 1'b1;
         // R10: a start for the other target while busy
         start_i   = (c == 3);
         tgt_sel_i = 1'(oth);
         if (fire) idx++;
         s_valid_i = (idx < n) && ($urandom % 4 != 0);
         s_data_i  = (idx < 16) ? mem[idx] : 8'h00;
         fire      = s_valid_i && s_ready_o;
      end
      start_i = 1'b0; s_valid_i = 1'b0;
      tag = (exp == 2) ? "R6 init timeout" : (exp == 3) ? "R8 done result" :
            (n == 0) ? "R9 zero count" : "R1 result";
      chk(got_fin, "R1 completion seen", int'(got_fin), 1);
      chk(res == exp, tag, res, exp);
      chk(low_cnt == PROG, "R5 program width", low_cnt, PROG);
      chk(wr_n == (ig ? n : 0), "R7 byte count", wr_n, ig ? n : 0);
      chk(mism == 0, "R7 byte order", mism, 0);
      chk(!en_end_bad, "R3 enable low at end", int'(en_end_bad), 0);
      chk(!oth_touch, "R10 other target untouched", int'(oth_touch), 0);
      if (n == 0) chk(!rdy_seen, "R9 no ready", int'(rdy_seen), 0);
      @(negedge clk);
      chk(!busy_o && !fin_o, "R1 idle after end", int'(busy_o), 0);
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4: reset state of pins
      chk(prog_n_o == 2'b11 && init_oe_o == 2'b11, "R4 reset pins", int'(init_oe_o), 3);
      chk(!busy_o && !fin_o && en_o == 2'b00 && !s_ready_o && !wr_stb_o,
          "R1 reset idle", int'(busy_o), 0);
      run_load(1, 3, 1'b0, 1'b1, 1'b1);  // R2 before any load of target 1
      run_load(0, 5, 1'b1, 1'b1, 1'b1);  // R1 success main
      run_load(1, 7, 1'b1, 1'b1, 1'b1);  // R3 target without enable
      run_load(0, 0, 1'b1, 1'b1, 1'b1);  // R9
      run_load(1, 4, 1'b1, 1'b0, 1'b1);  // R6
      run_load(0, 6, 1'b1, 1'b1, 1'b0);  // R8
      run_load(0, 2, 1'b0, 1'b1, 1'b1);  // R2 on main
      for (int k = 0; k < 10; k++) begin
         run_load(int'($urandom % 2), int'($urandom % 13), ($urandom % 6) != 0,
                  ($urandom % 4) != 0, ($urandom % 4) != 0);
      end
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

endmodule